// File: doc/BRIEF.md
# Serial Drum Sector Transfer Controller

This block controls a fixed-head serial drum attached to an 18-bit processor I/O bus. The processor issues I/O pulse commands in three groups: one loads a memory address together with a read/write direction, one loads a sector number (which also arms a transfer), tests the done flag and clears the flags, and one tests the error flag and continues at the current sector. A free-running word-position counter stands in for the spinning drum. When the armed sector's first word comes under the heads, the controller moves one sector of words between an external memory port and an external drum-storage port.

Writes are refused per group of sectors by a lock mask. Memory locations above the installed memory size are skipped silently on a read. After each sector the sector address moves on by one, so a continue command can go on into the next sector with the memory address carried along.

Both data outputs (memory write and drum write) use valid/ready. Once valid is raised, address and data are held until ready is seen. The only exception is a new arming command or a reset, which abandons the word. A stalled port delays the transfer word by word. The rotation counter keeps running regardless. Reads from memory and from the drum are combinational lookups on the address outputs.

Top module: `drum_xfer_ctl`

## Requirements
- R1: A group-0 strobe whose pulse ANDed with octal 027 equals octal 06 loads the memory address from the low MA_W bits of `io_ac` and latches the direction from pulse bit 5 (octal 040: 0 read, 1 write). Any other group-0 pulse changes nothing.
- R2: Group-1 pulse bit 2 loads the sector address from the low bits of `io_ac` and arms a transfer. Group-1 pulse bit 1 clears done and error. The sector address is visible as the upper bits of `drm_addr` (`drm_addr = {sector, word}`).
- R3: `io_skip` is high only while `io_strobe` is high. Within a strobe it is high for group-1 pulse bit 0 when done is set, and for group-2 pulse bit 0 when error is clear.
- R4: The position counter steps every WORD_TIME clocks and wraps at SPT*WPS. An armed transfer starts in the cycle the counter steps onto (sector mod SPT)*WPS. Arming while the counter already sits there waits a full revolution.
- R5: A read copies WPS words, drum word sector*WPS+i to memory address MA+i, with MA wrapping modulo 2^MA_W.
- R6: During a read, a word whose memory address is at or above MEM_WORDS is not written and raises no error, but MA still advances.
- R7: A write copies WPS words from memory MA+i to the drum, unless lock_mask bit (sector / LOCK_GRP) is set. In that case no drum word is written, the error flag sets, and MA still advances.
- R8: After the last word the sector address increments modulo the sector count and done sets. `irq` follows done.
- R9: Group-2 pulse bit 2 clears done and error and re-arms at the current sector with the same alignment rule.
- R10: While a data valid is high and its ready is low (and no command strobes), valid, address and data stay unchanged in the next cycle.
- R11: Reset clears the sector address, memory address, direction, done and error, and abandons any pending or running transfer.
- R12: Arming again while a transfer is waiting restarts the wait with the new sector. A command in the same cycle as transfer activity takes precedence.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| io_strobe | input | 1 | I/O command pulse present |
| io_sel | input | 2 | Command group (0 address, 1 sector/done, 2 status/continue) |
| io_pulse | input | 6 | Pulse bits of the command |
| io_ac | input | WORD_W | Accumulator value accompanying the command |
| io_skip | output | 1 | Skip response to a test command |
| irq | output | 1 | Done / interrupt request |
| lock_mask | input | SECTORS/LOCK_GRP | Write lock, one bit per sector group |
| mem_addr | output | MA_W | Memory word address (current MA) |
| mem_rdata | input | WORD_W | Memory word at `mem_addr` |
| mem_wr_valid | output | 1 | Memory write request |
| mem_wr_ready | input | 1 | Memory accepts the write |
| mem_wdata | output | WORD_W | Word to memory |
| drm_addr | output | log2(SECTORS*WPS) | Drum word address {sector, word} |
| drm_rdata | input | WORD_W | Drum word at `drm_addr` |
| drm_wr_valid | output | 1 | Drum write request |
| drm_wr_ready | input | 1 | Drum accepts the write |
| drm_wdata | output | WORD_W | Word to drum |

## Verification
The stability properties allow a pending word to be abandoned only by a command strobe or reset, so they are written to excuse any cycle with `io_strobe` high. The lock property assumes `lock_mask` is steady while a write sector runs. The stimulus therefore changes the mask only between transfers and issues commands mid-transfer only in the deliberate re-arm and reset cases. Ready is toggled on a fixed cycle pattern so that both ports see stalls on their own schedules. The memory model answers reads combinationally from the address, which is the behaviour the write-path checks rely on.

// File: rtl/drum_pkg.sv
package drum_pkg;
  typedef enum logic [1:0] {SEQ_IDLE, SEQ_WAIT, SEQ_XFER} seq_state_t;

  typedef struct packed {
    logic load_ma;
    logic func_wr;
    logic skip_done;
    logic clr_flags;
    logic sel_sector;
    logic skip_ok;
    logic cont;
  } io_cmd_t;

  localparam logic [1:0] GRP_ADDR = 2'd0;
  localparam logic [1:0] GRP_SECT = 2'd1;
  localparam logic [1:0] GRP_STAT = 2'd2;
  localparam logic [5:0] LOAD_MASK = 6'o27;
  localparam logic [5:0] LOAD_CODE = 6'o06;
endpackage

// File: rtl/drum_cmd_decode.sv
module drum_cmd_decode
  import drum_pkg::*;
(
  input  logic       io_strobe,
  input  logic [1:0] io_sel,
  input  logic [5:0] io_pulse,
  output io_cmd_t    cmd
);
  logic g_addr, g_sect, g_stat;

  assign g_addr = io_strobe && (io_sel == GRP_ADDR);
  assign g_sect = io_strobe && (io_sel == GRP_SECT);
  assign g_stat = io_strobe && (io_sel == GRP_STAT);

  always_comb begin
    cmd            = '0;
    cmd.load_ma    = g_addr && ((io_pulse & LOAD_MASK) == LOAD_CODE);
    cmd.func_wr    = io_pulse[5];
    cmd.skip_done  = g_sect && io_pulse[0];
    cmd.clr_flags  = g_sect && io_pulse[1];
    cmd.sel_sector = g_sect && io_pulse[2];
    cmd.skip_ok    = g_stat && io_pulse[0];
    cmd.cont       = g_stat && io_pulse[2];
  end
endmodule

// File: rtl/drum_rotor.sv
module drum_rotor #(
  parameter int WPT       = 512,
  parameter int WORD_TIME = 10
) (
  input  logic                   clk,
  input  logic                   rst_n,
  output logic                   step,
  output logic [$clog2(WPT)-1:0] pos_next
);
  localparam int POS_W = $clog2(WPT);
  localparam int DIV_W = $clog2(WORD_TIME + 1);

  logic [DIV_W-1:0] div;
  logic [POS_W-1:0] pos;

  assign step     = (div == DIV_W'(WORD_TIME - 1));
  assign pos_next = (pos == POS_W'(WPT - 1)) ? '0 : pos + 1'b1;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      div <= '0;
      pos <= '0;
    end else begin
      div <= step ? '0 : div + 1'b1;
      if (step) pos <= pos_next;
    end
  end
endmodule

// File: rtl/drum_sector_seq.sv
module drum_sector_seq
  import drum_pkg::*;
#(
  parameter int WORD_W    = 18,
  parameter int MA_W      = 16,
  parameter int WPS       = 256,
  parameter int SPT       = 2,
  parameter int SECTORS   = 512,
  parameter int LOCK_GRP  = 16,
  parameter int MEM_WORDS = 65536,
  localparam int SEC_W    = $clog2(SECTORS),
  localparam int WPS_W    = $clog2(WPS),
  localparam int SPT_W    = $clog2(SPT),
  localparam int POS_W    = SPT_W + WPS_W,
  localparam int LG_W     = $clog2(LOCK_GRP),
  localparam int LOCK_W   = SECTORS / LOCK_GRP
) (
  input  logic                    clk,
  input  logic                    rst_n,
  input  io_cmd_t                 cmd,
  input  logic [WORD_W-1:0]       io_ac,
  input  logic                    step,
  input  logic [POS_W-1:0]        pos_next,
  input  logic [LOCK_W-1:0]       lock_mask,
  output logic                    io_skip,
  output logic                    done,
  output logic [MA_W-1:0]         mem_addr,
  input  logic [WORD_W-1:0]       mem_rdata,
  output logic                    mem_wr_valid,
  input  logic                    mem_wr_ready,
  output logic [WORD_W-1:0]       mem_wdata,
  output logic [SEC_W+WPS_W-1:0]  drm_addr,
  input  logic [WORD_W-1:0]       drm_rdata,
  output logic                    drm_wr_valid,
  input  logic                    drm_wr_ready,
  output logic [WORD_W-1:0]       drm_wdata
);
  localparam logic [32:0] MEM_LIM = 33'(MEM_WORDS);

  seq_state_t       state;
  logic [SEC_W-1:0] sec;
  logic [MA_W-1:0]  ma;
  logic [WPS_W-1:0] wcnt;
  logic             fn_wr;
  logic             err;
  logic             in_range, locked, xfer, advance, aligned, last_word;
  logic [POS_W-1:0] target;

  assign target    = {sec[SPT_W-1:0], {WPS_W{1'b0}}};
  assign aligned   = step && (pos_next == target);
  assign in_range  = 33'(ma) < MEM_LIM;
  assign locked    = lock_mask[sec[SEC_W-1:LG_W]];
  assign xfer      = (state == SEQ_XFER);
  assign last_word = (wcnt == WPS_W'(WPS - 1));

  assign mem_wr_valid = xfer && !fn_wr && in_range;
  assign drm_wr_valid = xfer && fn_wr && !locked;
  assign advance      = xfer && (fn_wr ? (locked || drm_wr_ready)
                                       : (!in_range || mem_wr_ready));

  assign mem_addr  = ma;
  assign mem_wdata = drm_rdata;
  assign drm_addr  = {sec, wcnt};
  assign drm_wdata = mem_rdata;

  assign io_skip = (cmd.skip_done && done) || (cmd.skip_ok && !err);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state <= SEQ_IDLE;
      sec   <= '0;
      ma    <= '0;
      wcnt  <= '0;
      fn_wr <= 1'b0;
      done  <= 1'b0;
      err   <= 1'b0;
    end else begin
      unique case (state)
        SEQ_WAIT: if (aligned) begin
          state <= SEQ_XFER;
          wcnt  <= '0;
        end
        SEQ_XFER: if (advance) begin
          ma <= ma + 1'b1;
          if (fn_wr && locked) err <= 1'b1;
          if (last_word) begin
            sec   <= sec + 1'b1;
            done  <= 1'b1;
            state <= SEQ_IDLE;
          end else begin
            wcnt <= wcnt + 1'b1;
          end
        end
        default: ;
      endcase
      // commands override transfer activity in the same cycle
      if (cmd.load_ma) begin
        ma    <= io_ac[MA_W-1:0];
        fn_wr <= cmd.func_wr;
      end
      if (cmd.clr_flags || cmd.cont) begin
        done <= 1'b0;
        err  <= 1'b0;
      end
      if (cmd.sel_sector) begin
        sec   <= io_ac[SEC_W-1:0];
        state <= SEQ_WAIT;
      end
      if (cmd.cont) state <= SEQ_WAIT;
    end
  end
endmodule

// File: rtl/drum_xfer_ctl.sv
module drum_xfer_ctl
  import drum_pkg::*;
#(
  parameter int WORD_W    = 18,
  parameter int MA_W      = 16,
  parameter int WPS       = 256,
  parameter int SPT       = 2,
  parameter int TRACKS    = 256,
  parameter int WORD_TIME = 10,
  parameter int LOCK_GRP  = 16,
  parameter int MEM_WORDS = 65536,
  localparam int SECTORS  = SPT * TRACKS,
  localparam int WPT      = SPT * WPS,
  localparam int DA_W     = $clog2(SECTORS) + $clog2(WPS),
  localparam int LOCK_W   = SECTORS / LOCK_GRP
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              io_strobe,
  input  logic [1:0]        io_sel,
  input  logic [5:0]        io_pulse,
  input  logic [WORD_W-1:0] io_ac,
  output logic              io_skip,
  output logic              irq,
  input  logic [LOCK_W-1:0] lock_mask,
  output logic [MA_W-1:0]   mem_addr,
  input  logic [WORD_W-1:0] mem_rdata,
  output logic              mem_wr_valid,
  input  logic              mem_wr_ready,
  output logic [WORD_W-1:0] mem_wdata,
  output logic [DA_W-1:0]   drm_addr,
  input  logic [WORD_W-1:0] drm_rdata,
  output logic              drm_wr_valid,
  input  logic              drm_wr_ready,
  output logic [WORD_W-1:0] drm_wdata
);
  io_cmd_t                  cmd;
  logic                     step;
  logic [$clog2(WPT)-1:0]   pos_next;
  logic                     done;

  drum_cmd_decode u_dec (
    .io_strobe (io_strobe),
    .io_sel    (io_sel),
    .io_pulse  (io_pulse),
    .cmd       (cmd)
  );

  drum_rotor #(.WPT(WPT), .WORD_TIME(WORD_TIME)) u_rot (
    .clk      (clk),
    .rst_n    (rst_n),
    .step     (step),
    .pos_next (pos_next)
  );

  drum_sector_seq #(
    .WORD_W(WORD_W), .MA_W(MA_W), .WPS(WPS), .SPT(SPT),
    .SECTORS(SECTORS), .LOCK_GRP(LOCK_GRP), .MEM_WORDS(MEM_WORDS)
  ) u_seq (
    .clk          (clk),
    .rst_n        (rst_n),
    .cmd          (cmd),
    .io_ac        (io_ac),
    .step         (step),
    .pos_next     (pos_next),
    .lock_mask    (lock_mask),
    .io_skip      (io_skip),
    .done         (done),
    .mem_addr     (mem_addr),
    .mem_rdata    (mem_rdata),
    .mem_wr_valid (mem_wr_valid),
    .mem_wr_ready (mem_wr_ready),
    .mem_wdata    (mem_wdata),
    .drm_addr     (drm_addr),
    .drm_rdata    (drm_rdata),
    .drm_wr_valid (drm_wr_valid),
    .drm_wr_ready (drm_wr_ready),
    .drm_wdata    (drm_wdata)
  );

  assign irq = done;
endmodule

// File: rtl/drum_xfer_ctl_chk.sv
module drum_xfer_ctl_chk #(
  parameter int WORD_W    = 18,
  parameter int MA_W      = 16,
  parameter int DA_W      = 17,
  parameter int LOCK_W    = 32,
  parameter int LK_SHIFT  = 12,
  parameter int MEM_WORDS = 65536
) (
  input logic              clk,
  input logic              rst_n,
  input logic              io_strobe,
  input logic [1:0]        io_sel,
  input logic [5:0]        io_pulse,
  input logic              io_skip,
  input logic              irq,
  input logic [LOCK_W-1:0] lock_mask,
  input logic [MA_W-1:0]   mem_addr,
  input logic              mem_wr_valid,
  input logic              mem_wr_ready,
  input logic [WORD_W-1:0] mem_wdata,
  input logic [DA_W-1:0]   drm_addr,
  input logic              drm_wr_valid,
  input logic              drm_wr_ready,
  input logic [WORD_W-1:0] drm_wdata
);
  AST_SKIP_IN_STROBE: assert property (@(posedge clk) disable iff (!rst_n)
    io_skip |-> io_strobe); // R3
  AST_CLEAR_DROPS_DONE: assert property (@(posedge clk) disable iff (!rst_n)
    (io_strobe && io_sel == 2'd1 && io_pulse[1]) |=> !irq); // R2
  AST_CONT_DROPS_DONE: assert property (@(posedge clk) disable iff (!rst_n)
    (io_strobe && io_sel == 2'd2 && io_pulse[2]) |=> !irq); // R9
  AST_READ_IN_RANGE: assert property (@(posedge clk) disable iff (!rst_n)
    mem_wr_valid |-> (33'(mem_addr) < 33'(MEM_WORDS))); // R6
  AST_LOCKED_NO_WRITE: assert property (@(posedge clk) disable iff (!rst_n)
    drm_wr_valid |-> !lock_mask[drm_addr[DA_W-1:LK_SHIFT]]); // R7
  AST_ONE_DIRECTION: assert property (@(posedge clk) disable iff (!rst_n)
    !(mem_wr_valid && drm_wr_valid)); // R5
  AST_MA_STEPS: assert property (@(posedge clk) disable iff (!rst_n)
    (mem_wr_valid && mem_wr_ready && !io_strobe)
      |=> mem_addr == MA_W'($past(mem_addr) + 1'b1)); // R5
  AST_MEM_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
    (mem_wr_valid && !mem_wr_ready && !io_strobe)
      |=> (mem_wr_valid && $stable(mem_addr) && $stable(mem_wdata))); // R10
  AST_DRM_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
    (drm_wr_valid && !drm_wr_ready && !io_strobe)
      |=> (drm_wr_valid && $stable(drm_addr) && $stable(drm_wdata))); // R10
endmodule

bind drum_xfer_ctl drum_xfer_ctl_chk #(
  .WORD_W(WORD_W), .MA_W(MA_W), .DA_W(DA_W), .LOCK_W(LOCK_W),
  .LK_SHIFT($clog2(WPS) + $clog2(LOCK_GRP)), .MEM_WORDS(MEM_WORDS)
) u_chk (.*);

// File: tb/drum_xfer_ctl_bench.sv
module drum_xfer_ctl_bench;
  localparam int WW = 18, MAW = 6, WPS = 4, SPT = 2, TRK = 4, WT = 3;
  localparam int LG = 2, MEMW = 40, NSEC = SPT * TRK, WPT = SPT * WPS;
  localparam int NDRM = NSEC * WPS, NMEM = 1 << MAW;

  logic clk = 0, rst_n = 0;
  logic io_strobe = 0;
  logic [1:0] io_sel = '0;
  logic [5:0] io_pulse = '0;
  logic [WW-1:0] io_ac = '0;
  logic io_skip, irq;
  logic [NSEC/LG-1:0] lock_mask = 4'b0101;
  logic [MAW-1:0] mem_addr;
  logic [WW-1:0] mem_rdata, mem_wdata, drm_rdata, drm_wdata;
  logic mem_wr_valid, drm_wr_valid;
  logic mem_wr_ready = 1, drm_wr_ready = 1;
  logic [4:0] drm_addr;

  logic [WW-1:0] mem [NMEM];
  logic [WW-1:0] drum [NDRM];
  logic [WW-1:0] emem [NMEM];
  logic [WW-1:0] edrum [NDRM];
  int cyc = 0, cmd_cyc = 0, nvec = 0, nfail = 0, bp_bad = 0;
  bit stall_mode = 0;

  always #10 clk = ~clk;

  drum_xfer_ctl #(.WORD_W(WW), .MA_W(MAW), .WPS(WPS), .SPT(SPT), .TRACKS(TRK),
    .WORD_TIME(WT), .LOCK_GRP(LG), .MEM_WORDS(MEMW)) u_drum_xfer_ctl (.*);

  assign mem_rdata = mem[mem_addr];
  assign drm_rdata = drum[drm_addr];

  always @(posedge clk) begin
    if (!rst_n) cyc <= 0; else cyc <= cyc + 1;
    if (mem_wr_valid && mem_wr_ready) mem[mem_addr] <= mem_wdata;
    if (drm_wr_valid && drm_wr_ready) drum[drm_addr] <= drm_wdata;
  end

  always @(posedge clk) begin
    #5;
    mem_wr_ready = stall_mode ? (cyc % 3 != 1) : 1'b1;
    drm_wr_ready = stall_mode ? (cyc % 3 != 2) : 1'b1;
  end

  // back-pressure monitor (R10)
  logic p_mv = 0, p_mr = 0, p_dv = 0, p_dr = 0, p_st = 0;
  logic [MAW-1:0] p_ma; logic [4:0] p_da; logic [WW-1:0] p_md, p_dd;
  always @(negedge clk) begin
    #3;
    if (rst_n && p_mv && !p_mr && !p_st &&
        (!mem_wr_valid || mem_addr != p_ma || mem_wdata != p_md)) bp_bad++;
    if (rst_n && p_dv && !p_dr && !p_st &&
        (!drm_wr_valid || drm_addr != p_da || drm_wdata != p_dd)) bp_bad++;
    p_mv = mem_wr_valid; p_mr = mem_wr_ready; p_ma = mem_addr; p_md = mem_wdata;
    p_dv = drm_wr_valid; p_dr = drm_wr_ready; p_da = drm_addr; p_dd = drm_wdata;
    p_st = io_strobe || !rst_n;
  end

  task automatic chk(input bit ok, input string req, input longint act, input longint exp);
    nvec++;
    if (!ok) begin
      nfail++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  task automatic io_cmd(input logic [1:0] sel, input logic [5:0] p,
                        input logic [WW-1:0] ac, output bit sk);
    @(negedge clk); #1;
    io_strobe = 1; io_sel = sel; io_pulse = p; io_ac = ac;
    #2 sk = io_skip;
    @(posedge clk); #1;
    cmd_cyc = cyc; io_strobe = 0; io_pulse = '0;
  endtask

  task automatic run_xfer(input int s, input bit wr, input int ma0, input bit stall,
                          input bit cont, input int pre_s, input string tag);
    int a, n, tgt, first, errs, ad;
    bit vis, sk, lk;
    for (int i = 0; i < NMEM; i++) emem[i] = mem[i];
    for (int i = 0; i < NDRM; i++) edrum[i] = drum[i];
    stall_mode = stall;
    lk = wr && lock_mask[s / LG];
    if (cont) begin
      io_cmd(2'd2, 6'o04, '0, sk);
      #2 chk(irq == 1'b0, "R9 continue clears done", irq, 0);
    end else begin
      io_cmd(2'd1, 6'o02, '0, sk);
      io_cmd(2'd0, wr ? 6'o46 : 6'o06, WW'(ma0), sk);
      if (pre_s >= 0) io_cmd(2'd1, 6'o04, WW'(pre_s), sk);
      io_cmd(2'd1, 6'o04, WW'(s), sk);
    end
    a = cmd_cyc;
    tgt = (s % SPT) * WPS;
    n = a + 1;
    while (!((n % WT == 0) && ((n / WT) % WPT == tgt))) n++;
    vis = wr ? !lk : (ma0 < MEMW);
    first = -1;
    for (int k = 0; k < 400 && !irq; k++) begin
      @(negedge clk); #3;
      if (first < 0 && (mem_wr_valid || drm_wr_valid)) first = cyc;
    end
    if (vis) chk(first == n, {"R4 start alignment ", tag}, first, n);
    chk(irq == 1'b1, {"R8 done after sector ", tag}, irq, 1);
    for (int i = 0; i < WPS; i++) begin
      ad = (ma0 + i) % NMEM;
      if (wr) begin
        if (!lk) edrum[s * WPS + i] = emem[ad];
      end else if (ad < MEMW) emem[ad] = edrum[s * WPS + i];
    end
    errs = 0;
    for (int i = 0; i < NMEM; i++) if (mem[i] !== emem[i]) errs++;
    for (int i = 0; i < NDRM; i++) if (drum[i] !== edrum[i]) errs++;
    chk(errs == 0, {"data ", tag}, errs, 0);
    io_cmd(2'd2, 6'o01, '0, sk);
    chk(sk == !lk, {"R7 error flag via skip ", tag}, sk, !lk);
  endtask

  initial begin
    #(20 * 150000);
    nfail++;
    $display("FAIL watchdog expired");
    $display("== %0d vectors applied, %0d miscompares ==", nvec, nfail);
    $finish;
  end

  initial begin
    bit sk;
    int ok;
    for (int i = 0; i < NMEM; i++) mem[i] = WW'(18'h20000 | (i * 5));
    for (int i = 0; i < NDRM; i++) drum[i] = WW'(18'h01000 + i * 37);
    repeat (3) @(negedge clk);
    #1 rst_n = 1;
    @(negedge clk); #3;
    // R11 reset state
    chk(irq == 0, "R11 irq after reset", irq, 0);
    chk(mem_addr == 0 && drm_addr == 0, "R11 addresses after reset", {mem_addr, drm_addr}, 0);
    chk(!mem_wr_valid && !drm_wr_valid, "R11 no request after reset", {mem_wr_valid, drm_wr_valid}, 0);
    io_cmd(2'd1, 6'o01, '0, sk); chk(sk == 0, "R3 skip-done when clear", sk, 0);
    io_cmd(2'd2, 6'o01, '0, sk); chk(sk == 1, "R3 skip-ok when no error", sk, 1);
    #2 chk(io_skip == 0, "R3 no skip without strobe", io_skip, 0);
    // R1 load decode
    io_cmd(2'd0, 6'o06, 18'h3FF25, sk); #2 chk(mem_addr == 6'h25, "R1 load 06", mem_addr, 6'h25);
    io_cmd(2'd0, 6'o16, 18'h00011, sk); #2 chk(mem_addr == 6'h11, "R1 load 16", mem_addr, 6'h11);
    io_cmd(2'd0, 6'o07, 18'h00033, sk); #2 chk(mem_addr == 6'h11, "R1 pulse 07 ignored", mem_addr, 6'h11);
    io_cmd(2'd1, 6'o00, 18'h00033, sk); #2 chk(mem_addr == 6'h11, "R1 other group ignored", mem_addr, 6'h11);
    // R2 sector load
    io_cmd(2'd1, 6'o04, 18'h3FFF5, sk); #2 chk(drm_addr[4:2] == 3'd5, "R2 sector load", drm_addr[4:2], 5);
    for (int k = 0; k < 200 && !irq; k++) @(negedge clk);
    #3 chk(irq == 1, "R8 done after first sector", irq, 1);
    io_cmd(2'd1, 6'o01, '0, sk); chk(sk == 1, "R3 skip-done when set", sk, 1);
    io_cmd(2'd1, 6'o02, '0, sk); #2 chk(irq == 0, "R2 clear flags", irq, 0);
    // sweep: every sector, both directions
    for (int s = 0; s < NSEC; s++) begin
      run_xfer(s, 1'b0, (s * 9 + 30) % NMEM, s[0], 1'b0, -1, "R5 R6 read sweep");
      run_xfer(s, 1'b1, (s * 7) % NMEM, !s[0], 1'b0, -1, "R7 write sweep");
    end
    // continue into next sector
    run_xfer(2, 1'b0, 10, 1'b0, 1'b0, -1, "R5 read s2");
    run_xfer(3, 1'b0, 14, 1'b1, 1'b1, -1, "R9 continue s3");
    // memory address wrap and sector wrap
    run_xfer(7, 1'b0, 62, 1'b0, 1'b0, -1, "R5 R6 wrap");
    run_xfer(0, 1'b0, 2, 1'b0, 1'b1, -1, "R8 sector wrap");
    // re-arm while waiting
    run_xfer(6, 1'b0, 20, 1'b0, 1'b0, 3, "R12 rearm");
    // reset while waiting
    io_cmd(2'd1, 6'o02, '0, sk);
    io_cmd(2'd0, 6'o06, 18'd5, sk);
    io_cmd(2'd1, 6'o04, 18'd1, sk);
    @(negedge clk); #1 rst_n = 0;
    repeat (2) @(negedge clk);
    #1 rst_n = 1;
    ok = 1;
    for (int k = 0; k < 3 * WPT * WT; k++) begin
      @(negedge clk); #3;
      if (mem_wr_valid || drm_wr_valid || irq) ok = 0;
    end
    chk(ok == 1, "R11 reset abandons pending transfer", ok, 1);
    run_xfer(0, 1'b0, 0, 1'b0, 1'b1, -1, "R11 continue from reset state");
    chk(bp_bad == 0, "R10 valid held under back-pressure", bp_bad, 0);
    $display("== %0d vectors applied, %0d miscompares ==", nvec, nfail);
    $finish;
  end
endmodule